// File: doc/BRIEF.md
# Background and Window Tile Fetcher

This block fetches one 8-pixel row of tile graphics for a scanline display engine. A fetch can come from the scrolled background layer or from the window layer. On a start request it latches the layer choice, the map and addressing controls, and a tile-map address. That address is formed from the current line, the current pixel X, the scroll or window offsets, and the FIFO occupancy. The block then makes three reads through a synchronous video-RAM port. The first read returns the tile index. The second and third return the low and high bitplane bytes of the selected pixel row. The block packs the eight pixels into one 32-bit word and pushes it into a downstream pixel FIFO once that FIFO has space for a whole tile.

The surrounding pipeline starts one fetch per 8-pixel slot. It chooses the layer for each fetch with `fetch_win_i`. While it waits for the result it watches `busy_o`. Object fetching, palette lookup and pixel mixing are done elsewhere.

Top module: `bg_tile_fetcher`

## Requirements
- R1: While reset is applied and in the first cycle after it, `vram_rd_o`, `push_o` and `busy_o` are all 0.
- R2: A fetch that is accepted makes exactly three reads. Each read holds its address with `vram_rd_o` high for two consecutive cycles. The order is: tile-map entry, low bitplane byte at address A, high bitplane byte at A+1. The first read starts in the cycle after `fetch_start_i` is sampled in the idle state.
- R3: For a background fetch, the map entry address is B + 32×(row/8) + col/8. Here col = (X + `scx_i`) mod 256 and row = (`ly_i` + `scy_i`) mod 256. B is 0x1C00 when `bg_map_hi_i` is 1 and 0x1800 when it is 0.
- R4: For a window fetch, the map entry address is B + 32×(row/8) + col/8. Here col = (X − `wx_i`) mod 256 and row = (`ly_i` − `wy_i`) mod 256. B is 0x1C00 when `win_map_hi_i` is 1 and 0x1800 when it is 0.
- R5: X is `pix_x_i` when `fifo_level_i` is 0 at start. Otherwise X is (`pix_x_i` + 8) mod 256, so that the following tile is fetched.
- R6: When `tile_unsigned_i` is 1, the low bitplane address is 16×index + 2×(row mod 8), where row is the layer row from R3 or R4.
- R7: When `tile_unsigned_i` is 0, the index is read as a signed 8-bit value. The low bitplane address is (0x1000 + 16×signed index + 2×(row mod 8)) mod 8192.
- R8: Pixel n (0..7) sits in bits [31−4n : 28−4n] of `push_pixels_o`. Bit 0 of the nibble is bit 7−n of the low byte and bit 1 is bit 7−n of the high byte. Bits [3:2] are 00 for background and 01 for window.
- R9: `push_o` is high for exactly one cycle per fetch, and only while `fifo_level_i` ≤ FIFO_DEPTH − 8. Until that holds, the push waits with `busy_o` high. The fetcher is idle in the cycle after the push.
- R10: A start request while `busy_o` is high is ignored. Changes to layer, control, scroll, window, line, X or level inputs after a fetch starts have no effect on that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_start_i | input | 1 | Start one tile fetch (sampled when idle) |
| fetch_win_i | input | 1 | 1 = window layer, 0 = background |
| bg_map_hi_i | input | 1 | Background map at 0x1C00 (1) or 0x1800 (0) |
| win_map_hi_i | input | 1 | Window map at 0x1C00 (1) or 0x1800 (0) |
| tile_unsigned_i | input | 1 | Unsigned tile indexing from 0 (1) or signed around 0x1000 (0) |
| scx_i | input | 8 | Horizontal scroll |
| scy_i | input | 8 | Vertical scroll |
| wx_i | input | 8 | Window X origin |
| wy_i | input | 8 | Window Y origin |
| ly_i | input | 8 | Current line |
| pix_x_i | input | 8 | Current output pixel X |
| fifo_level_i | input | 5 | Pixels currently held in the FIFO |
| vram_rd_o | output | 1 | VRAM read strobe |
| vram_addr_o | output | 13 | VRAM read address |
| vram_data_i | input | 8 | VRAM read data, registered one cycle after address |
| push_o | output | 1 | Push packed row into FIFO |
| push_pixels_o | output | 32 | Eight 4-bit pixels, pixel 0 in the top nibble |
| busy_o | output | 1 | A fetch is in progress |

## Verification
Two situations are hardest to reach from the ports. The first is a fetch that finishes while the FIFO has no room, which leaves the block waiting with its row ready. The bench reaches it by starting a fetch with a high occupancy level. It then checks over several cycles that no push appears, and only after that lowers the level and expects the push at once. The second is a start request in the middle of a fetch. The bench raises start with a different layer while changing every register input. It then checks that the addresses and the pushed row still match the values latched at the original start. Around these, a sweep covers both layers, all map and indexing controls, scroll and window values that wrap past 255, and both occupancy cases.

// File: rtl/tf_pkg.sv
package tf_pkg;

  localparam int VRAM_AW = 13;
  localparam int TILE_B  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAP_A,
    ST_MAP_B,
    ST_LO_A,
    ST_LO_B,
    ST_HI_A,
    ST_HI_B,
    ST_PUSH
  } fetch_st_t;

  // map entry: base + 32 * tile row + tile column
  function automatic logic [VRAM_AW-1:0] map_entry_addr(
    input logic [VRAM_AW-1:0] base,
    input logic [7:0]         row,
    input logic [7:0]         col
  );
    return base + {{(VRAM_AW-10){1'b0}}, row[7:3], col[7:3]};
  endfunction

  // low bitplane address of one row of one tile
  function automatic logic [VRAM_AW-1:0] tile_row_addr(
    input logic       unsigned_mode,
    input logic [7:0] idx,
    input logic [2:0] fine
  );
    logic [VRAM_AW-1:0] start;
    if (unsigned_mode)
      start = {1'b0, idx, 4'b0000};
    else
      start = 13'h1000 + {idx[7], idx, 4'b0000};
    return start + {{(VRAM_AW-4){1'b0}}, fine, 1'b0};
  endfunction

endpackage

// File: rtl/tf_map_addr.sv
module tf_map_addr
  import tf_pkg::*;
#(
  parameter logic [VRAM_AW-1:0] MAP_LO = 13'h1800,
  parameter logic [VRAM_AW-1:0] MAP_HI = 13'h1C00
) (
  input  logic               win_sel,
  input  logic               bg_hi,
  input  logic               win_hi,
  input  logic [7:0]         x_eff,
  input  logic [7:0]         scx,
  input  logic [7:0]         scy,
  input  logic [7:0]         wx,
  input  logic [7:0]         wy,
  input  logic [7:0]         ly,
  output logic [VRAM_AW-1:0] map_addr,
  output logic [2:0]         fine_row
);

  logic [7:0]         col, row;
  logic [VRAM_AW-1:0] base;

  always_comb begin
    if (win_sel) begin
      col  = x_eff - wx;
      row  = ly - wy;
      base = win_hi ? MAP_HI : MAP_LO;
    end else begin
      col  = x_eff + scx;
      row  = ly + scy;
      base = bg_hi ? MAP_HI : MAP_LO;
    end
    map_addr = map_entry_addr(base, row, col);
    fine_row = row[2:0];
  end

endmodule

// File: rtl/tf_tile_addr.sv
module tf_tile_addr
  import tf_pkg::*;
(
  input  logic               unsigned_mode,
  input  logic [7:0]         idx,
  input  logic [2:0]         fine,
  output logic [VRAM_AW-1:0] lo_addr
);

  assign lo_addr = tile_row_addr(unsigned_mode, idx, fine);

  always_comb begin
    if (unsigned_mode)
      assert (lo_addr < 13'h1000) else $error("p_unsigned_range_r6");
    else
      assert (lo_addr >= 13'h0800 && lo_addr < 13'h1800) else $error("p_signed_range_r7");
  end

endmodule

// File: rtl/tf_row_pack.sv
module tf_row_pack #(
  parameter int NPIX  = 8,
  parameter int NIB_W = 4,
  localparam int WORD_W = NPIX * NIB_W
) (
  input  logic [NPIX-1:0]   plane_lo,
  input  logic [NPIX-1:0]   plane_hi,
  input  logic [NIB_W-3:0]  src,
  output logic [WORD_W-1:0] word
);

  for (genvar n = 0; n < NPIX; n++) begin : g_pix
    assign word[WORD_W-1-NIB_W*n -: NIB_W] = {src, plane_hi[NPIX-1-n], plane_lo[NPIX-1-n]};
  end

endmodule

// File: rtl/bg_tile_fetcher.sv
module bg_tile_fetcher
  import tf_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TILE_PX    = TILE_B,
  parameter int NIB_W      = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int WORD_W    = TILE_PX * NIB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_start_i,
  input  logic               fetch_win_i,
  input  logic               bg_map_hi_i,
  input  logic               win_map_hi_i,
  input  logic               tile_unsigned_i,
  input  logic [7:0]         scx_i,
  input  logic [7:0]         scy_i,
  input  logic [7:0]         wx_i,
  input  logic [7:0]         wy_i,
  input  logic [7:0]         ly_i,
  input  logic [7:0]         pix_x_i,
  input  logic [LVL_W-1:0]   fifo_level_i,
  output logic               vram_rd_o,
  output logic [VRAM_AW-1:0] vram_addr_o,
  input  logic [7:0]         vram_data_i,
  output logic               push_o,
  output logic [WORD_W-1:0]  push_pixels_o,
  output logic               busy_o
);

  localparam logic [LVL_W-1:0] ROOM_LVL = LVL_W'(FIFO_DEPTH - TILE_PX);

  fetch_st_t          st_q, st_d;
  logic               win_q, uns_q;
  logic [VRAM_AW-1:0] map_q, data_addr_q;
  logic [2:0]         fine_q;
  logic [7:0]         lo_q, hi_q;

  logic [7:0]         x_eff;
  logic [VRAM_AW-1:0] map_c, tile_c;
  logic [2:0]         fine_c;

  // named internal events
  logic ev_accept, ev_open, ev_hi_open, room_ok, in_read;

  assign ev_accept  = (st_q == ST_IDLE) && fetch_start_i;
  assign ev_open    = (st_q == ST_MAP_A) || (st_q == ST_LO_A) || (st_q == ST_HI_A);
  assign ev_hi_open = (st_q == ST_HI_A);
  assign in_read    = (st_q != ST_IDLE) && (st_q != ST_PUSH);
  assign room_ok    = fifo_level_i <= ROOM_LVL;

  assign x_eff = pix_x_i + ((fifo_level_i != '0) ? 8'(TILE_PX) : 8'd0);

  tf_map_addr u_map (
    .win_sel  (fetch_win_i),
    .bg_hi    (bg_map_hi_i),
    .win_hi   (win_map_hi_i),
    .x_eff    (x_eff),
    .scx      (scx_i),
    .scy      (scy_i),
    .wx       (wx_i),
    .wy       (wy_i),
    .ly       (ly_i),
    .map_addr (map_c),
    .fine_row (fine_c)
  );

  tf_tile_addr u_tile (
    .unsigned_mode (uns_q),
    .idx           (vram_data_i),
    .fine          (fine_q),
    .lo_addr       (tile_c)
  );

  tf_row_pack #(.NPIX(TILE_PX), .NIB_W(NIB_W)) u_pack (
    .plane_lo (lo_q),
    .plane_hi (hi_q),
    .src      ({{(NIB_W-3){1'b0}}, win_q}),
    .word     (push_pixels_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (fetch_start_i) st_d = ST_MAP_A;
      ST_MAP_A: st_d = ST_MAP_B;
      ST_MAP_B: st_d = ST_LO_A;
      ST_LO_A:  st_d = ST_LO_B;
      ST_LO_B:  st_d = ST_HI_A;
      ST_HI_A:  st_d = ST_HI_B;
      ST_HI_B:  st_d = ST_PUSH;
      ST_PUSH:  if (room_ok) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      win_q       <= 1'b0;
      uns_q       <= 1'b0;
      map_q       <= '0;
      fine_q      <= '0;
      data_addr_q <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
    end else begin
      st_q <= st_d;
      if (ev_accept) begin
        win_q  <= fetch_win_i;
        uns_q  <= tile_unsigned_i;
        map_q  <= map_c;
        fine_q <= fine_c;
      end
      if (st_q == ST_MAP_B) data_addr_q <= tile_c;
      if (st_q == ST_LO_B) begin
        lo_q        <= vram_data_i;
        data_addr_q <= data_addr_q + 1'b1;
      end
      if (st_q == ST_HI_B) hi_q <= vram_data_i;
    end
  end

  assign vram_rd_o   = in_read;
  assign vram_addr_o = ((st_q == ST_MAP_A) || (st_q == ST_MAP_B)) ? map_q : data_addr_q;
  assign push_o      = (st_q == ST_PUSH) && room_ok;
  assign busy_o      = (st_q != ST_IDLE);

  // each read keeps its address for a second cycle
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_open |=> (vram_rd_o && $stable(vram_addr_o)));

  // high bitplane directly follows the low one
  p_hi_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hi_open |-> (vram_addr_o == $past(vram_addr_o) + 1'b1));

  // no push into a FIFO without space for a full tile
  p_push_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (fifo_level_i <= ROOM_LVL));

  // one push, then idle
  p_push_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> (!push_o && !busy_o));

  // a start while busy does not restart the read sequence
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && fetch_start_i && !push_o) |=> busy_o);

  // idle means no VRAM traffic
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!vram_rd_o && !push_o));

endmodule

// File: tb/bg_tile_fetcher_tb_top.sv
`timescale 1ns/100ps
module bg_tile_fetcher_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_start_i = 1'b0, fetch_win_i = 1'b0;
  logic        bg_map_hi_i = 1'b0, win_map_hi_i = 1'b0, tile_unsigned_i = 1'b0;
  logic [7:0]  scx_i = '0, scy_i = '0, wx_i = '0, wy_i = '0, ly_i = '0, pix_x_i = '0;
  logic [4:0]  fifo_level_i = '0;
  logic        vram_rd_o, push_o, busy_o;
  logic [12:0] vram_addr_o;
  logic [7:0]  vram_data_i = '0;
  logic [31:0] push_pixels_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  bg_tile_fetcher dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_start_i(fetch_start_i), .fetch_win_i(fetch_win_i),
    .bg_map_hi_i(bg_map_hi_i), .win_map_hi_i(win_map_hi_i),
    .tile_unsigned_i(tile_unsigned_i),
    .scx_i(scx_i), .scy_i(scy_i), .wx_i(wx_i), .wy_i(wy_i),
    .ly_i(ly_i), .pix_x_i(pix_x_i), .fifo_level_i(fifo_level_i),
    .vram_rd_o(vram_rd_o), .vram_addr_o(vram_addr_o), .vram_data_i(vram_data_i),
    .push_o(push_o), .push_pixels_o(push_pixels_o), .busy_o(busy_o)
  );

  function automatic int mv(input int a);
    return ((a * 29) ^ (a >> 5) ^ 'h5A) & 255;
  endfunction

  always @(posedge clk) if (vram_rd_o) vram_data_i <= 8'(mv(int'(vram_addr_o)));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference values from the requirements
  task automatic model(input int win, lc, sx, sy, wx, wy, ly, x, lvl,
                       output int map, output int ta, output int word);
    int xe, col, row, base, idx, sidx, lo, hi, c;
    xe = (x + ((lvl != 0) ? 8 : 0)) & 255;
    if (win != 0) begin
      col = (xe - wx) & 255; row = (ly - wy) & 255;
      base = ((lc & 'h40) != 0) ? 'h1C00 : 'h1800;
    end else begin
      col = (xe + sx) & 255; row = (ly + sy) & 255;
      base = ((lc & 'h08) != 0) ? 'h1C00 : 'h1800;
    end
    map = base + (row / 8) * 32 + col / 8;
    idx = mv(map);
    if ((lc & 'h10) != 0) ta = idx * 16 + (row % 8) * 2;
    else begin
      sidx = (idx >= 128) ? idx - 256 : idx;
      ta = ('h1000 + sidx * 16 + (row % 8) * 2) & 'h1FFF;
    end
    lo = mv(ta); hi = mv(ta + 1);
    word = 0;
    for (int n = 0; n < 8; n++) begin
      c = (((hi >> (7 - n)) & 1) * 2) + ((lo >> (7 - n)) & 1);
      word = word | ((((win != 0) ? 4 : 0) | c) << (28 - 4 * n));
    end
  endtask

  task automatic run_fetch(input int win, lc, sx, sy, wx, wy, ly, x, lvl, input bit disturb);
    int got[6];
    int n = 0;
    int word = 0;
    bit pushed = 0;
    int e_map, e_ta, e_word;
    model(win, lc, sx, sy, wx, wy, ly, x, lvl, e_map, e_ta, e_word);
    @(negedge clk);
    fetch_win_i = win[0]; bg_map_hi_i = lc[3]; tile_unsigned_i = lc[4]; win_map_hi_i = lc[6];
    scx_i = 8'(sx); scy_i = 8'(sy); wx_i = 8'(wx); wy_i = 8'(wy);
    ly_i = 8'(ly); pix_x_i = 8'(x); fifo_level_i = 5'(lvl);
    fetch_start_i = 1'b1;
    @(negedge clk);
    fetch_start_i = 1'b0;
    for (int c = 0; c < 40 && !pushed; c++) begin
      #1;
      if (vram_rd_o && n < 6) begin got[n] = int'(vram_addr_o); n++; end
      if (push_o) begin word = int'(push_pixels_o); pushed = 1; end
      if (disturb && c == 1) begin
        // R10: restart attempt and register changes mid-fetch
        fetch_start_i = 1'b1; fetch_win_i = ~fetch_win_i;
        tile_unsigned_i = ~tile_unsigned_i; bg_map_hi_i = ~bg_map_hi_i;
        scx_i = scx_i + 8'd8; ly_i = ly_i + 8'd1; pix_x_i = pix_x_i + 8'd16;
      end
      if (disturb && c == 2) fetch_start_i = 1'b0;
      if (!pushed) @(negedge clk);
    end
    chk($sformatf("R2 read sequence %0s", disturb ? "R10" : ""),
        (n == 6 && got[1] == got[0] && got[3] == got[2] && got[5] == got[4] &&
         got[4] == ((got[2] + 1) & 'h1FFF)) ? 1 : 0, 1);
    chk($sformatf("%0s%0s map addr%0s", win != 0 ? "R4" : "R3", lvl != 0 ? " R5" : "",
        disturb ? " R10" : ""), got[0], e_map);
    chk($sformatf("%0s tile addr", ((lc & 'h10) != 0) ? "R6" : "R7"), got[2], e_ta);
    chk($sformatf("R8 packed row%0s", disturb ? " R10" : ""), word, e_word);
    chk("R9 push seen", pushed ? 1 : 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sxs[4] = '{0, 3, 8, 250};
    int sys[3] = '{0, 5, 255};
    int lys[3] = '{0, 7, 143};
    int xs[3]  = '{0, 9, 160};
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset rd", int'(vram_rd_o), 0);
    chk("R1 reset push", int'(push_o), 0);
    chk("R1 reset busy", int'(busy_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 post-reset busy", int'(busy_o), 0);
    chk("R1 post-reset rd", int'(vram_rd_o), 0);

    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 8; m++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 3; b++)
            for (int l = 0; l < 3; l++)
              for (int xi = 0; xi < 3; xi++)
                for (int lv = 0; lv < 2; lv++) begin
                  int lc;
                  lc = (m[0] ? 'h08 : 0) | (m[1] ? 'h10 : 0) | (m[2] ? 'h40 : 0);
                  run_fetch(w, lc, sxs[a], sys[b], sxs[a] ^ 7, sys[b] + 2,
                            lys[l], xs[xi], lv * 4, 1'b0);
                end

    // R10: mid-fetch restart and register changes ignored
    run_fetch(0, 'h08, 12, 3, 0, 0, 20, 40, 0, 1'b1);
    run_fetch(1, 'h40, 0, 0, 7, 10, 50, 88, 3, 1'b1);

    // R9: back-pressure holds the push
    begin
      int e_map, e_ta, e_word, held;
      model(0, 'h18, 5, 9, 0, 0, 33, 72, 12, e_map, e_ta, e_word);
      @(negedge clk);
      fetch_win_i = 1'b0; bg_map_hi_i = 1'b1; tile_unsigned_i = 1'b1; win_map_hi_i = 1'b0;
      scx_i = 8'd5; scy_i = 8'd9; ly_i = 8'd33; pix_x_i = 8'd72; fifo_level_i = 5'd12;
      fetch_start_i = 1'b1;
      @(negedge clk);
      fetch_start_i = 1'b0;
      held = 0;
      for (int c = 0; c < 12; c++) begin
        #1;
        if (push_o) held++;
        @(negedge clk);
      end
      #1;
      chk("R9 no push while FIFO full", held, 0);
      chk("R9 busy while waiting", int'(busy_o), 1);
      fifo_level_i = 5'd8;
      #1;
      chk("R9 push once room", int'(push_o), 1);
      chk("R8 R5 held row data", int'(push_pixels_o), e_word);
      @(negedge clk);
      #1;
      chk("R9 single push", int'(push_o), 0);
      chk("R9 idle after push", int'(busy_o), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule